// File: doc/BRIEF.md
# Burst ROM Line Read Controller

This block fetches one cache-line-sized run of data from an asynchronous ROM that supports page-mode bursts on a 32-bit data bus. A single accepted request produces four consecutive 32-bit reads that cover one 16-byte line. The controller drives the ROM's active-low chip select, read strobe and bus-start strobe. It also drives the read/write level and a word address that steps by one word for each beat. It samples the returned data and hands each word downstream.

Two wait counts are taken at the moment a request is accepted. The first count stretches the first beat, which has to cover the full random access time of the ROM. The second count stretches every later beat, which only has to cover the shorter page access time. The cycle order within one chip-select window is fixed. It begins with a start cycle, then the first-access waits, then a data cycle. Each of the middle beats then takes its burst waits and a data cycle. The final beat takes its burst waits and ends on a closing data cycle.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle. A requester may hold `req_valid` high for as long as it likes, and the request is taken on the first cycle in which both are high. Responses are a one-cycle `rsp_valid` pulse per beat and cannot be back-pressured. The ROM delivers its data at a fixed rate, so the consumer must take every word in the cycle it is offered.

Top module: `brom_burst_rd`

## Requirements
- R1: While reset is asserted and after it is released, `rom_cs_n`, `rom_rd_n` and `rom_bs_n` are high, `rom_rdwr` is high, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the transfer ends. `rom_bs_n` is low only in the single cycle that follows the accepting edge.
- R3: `rom_cs_n` and `rom_rd_n` are low, and `rom_rdwr` is high, in every cycle from the first cycle of a transfer through the data cycle of the fourth beat.
- R4: The first beat lasts 2 + F cycles, where F is the `cfg_first_wait` value (0 to 7) captured at acceptance. That is one start cycle, F wait cycles and one data cycle.
- R5: Each of beats two to four lasts 1 + B cycles, where B is the `cfg_burst_wait` value (0 to 7) captured at acceptance. That is B wait cycles and one data cycle.
- R6: The line base is `req_addr` with its low 4 bits forced to zero. Beat k (k = 0..3) presents the address base + 4*k on `rom_addr` during its data cycle.
- R7: In the cycle after each data cycle, `rsp_valid` is high for exactly one cycle and `rsp_data` equals the value that was on `rom_data` at the end of that data cycle. `rsp_last` is high only with the fourth word.
- R8: Changes to `cfg_first_wait`, `cfg_burst_wait` or `req_addr` after the accepting edge have no effect on the transfer in progress.
- R9: After the fourth data cycle, all strobes are high for at least one cycle before the next start cycle, even when `req_valid` is held high throughout.
- R10: A wait count of zero removes the corresponding wait cycles entirely. With both counts zero, a line takes exactly five cycles of chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line read request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 26 | Byte address inside the wanted line |
| cfg_first_wait | input | 3 | Wait cycles for the first beat |
| cfg_burst_wait | input | 3 | Wait cycles for each later beat |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds a word |
| rsp_data | output | 32 | Word read from the ROM |
| rsp_last | output | 1 | Marks the fourth word of the line |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_rd_n | output | 1 | ROM read strobe, active low |
| rom_bs_n | output | 1 | Bus-start strobe, active low, first cycle only |
| rom_rdwr | output | 1 | Read/write level, always high (read) |
| rom_addr | output | 26 | Byte address of the current beat |
| rom_data | input | 32 | Data returned by the ROM |

## Verification
The hardest case to reach from the ports has three parts at once. A requester holds `req_valid` high straight through the end of a burst, the next request arrives with different wait counts, and the wait inputs are changed while a line is still in flight. The stimulus keeps `req_valid` asserted across the closing data cycle and drives a new address and counts in the single idle cycle. It also drives deliberately wrong counts and a wrong address right after each acceptance. The bench then checks that exactly one strobe-free cycle separates the two lines and that every beat keeps the length and address fixed at acceptance.

// File: rtl/brom_pkg.sv
package brom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_TW   = 3'd2,
    ST_TB2  = 3'd3,
    ST_TWB  = 3'd4,
    ST_T2   = 3'd5
  } brom_state_e;

endpackage

// File: rtl/brom_wait_timer.sv
module brom_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire = (cnt_q == CNT_W'(1));

  // R4
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/brom_addr_gen.sv
module brom_addr_gen #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              inc,
  output logic [$clog2(BEATS)-1:0] beat_idx,
  output logic              last_beat,
  output logic [ADDR_W-1:0] addr
);

  localparam int IDX_W  = $clog2(BEATS);
  localparam int LANE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = IDX_W + LANE_W;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'((1 << OFF_W) - 1);

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (start) begin
      base_q <= start_addr & LINE_MASK;
      idx_q  <= '0;
    end else if (inc) begin
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign offset    = {{(ADDR_W-OFF_W){1'b0}}, idx_q, {LANE_W{1'b0}}};
  assign addr      = base_q | offset;
  assign beat_idx  = idx_q;
  assign last_beat = (idx_q == IDX_W'(BEATS - 1));

  // R6
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !start) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

endmodule

// File: rtl/brom_rd_capture.sv
module brom_rd_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              sample_last,
  input  logic [DATA_W-1:0] bus_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);

  logic              vld_q;
  logic              last_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= sample;
      last_q <= sample && sample_last;
      if (sample) data_q <= bus_data;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;
  assign rsp_last  = last_q;

  // R7
  last_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> !rsp_valid);

endmodule

// File: rtl/brom_burst_rd.sv
module brom_burst_rd
  import brom_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WAIT_W-1:0] cfg_first_wait,
  input  logic [WAIT_W-1:0] cfg_burst_wait,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              rom_cs_n,
  output logic              rom_rd_n,
  output logic              rom_bs_n,
  output logic              rom_rdwr,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data
);

  localparam int IDX_W = $clog2(BEATS);

  brom_state_e       state_q, state_d;
  logic [WAIT_W-1:0] first_q, burst_q;
  logic              accept;
  logic              tmr_load, tmr_expire;
  logic [WAIT_W-1:0] tmr_val;
  logic [IDX_W-1:0]  beat_idx;
  logic              last_beat, penult;
  logic              busy;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= '0;
      burst_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        first_q <= cfg_first_wait;
        burst_q <= cfg_burst_wait;
      end
    end
  end

  assign tmr_load = (state_q == ST_T1) || (state_q == ST_TB2);
  assign tmr_val  = (state_q == ST_T1) ? first_q : burst_q;

  brom_wait_timer #(.CNT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  brom_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (req_addr),
    .inc        (state_q == ST_TB2),
    .beat_idx   (beat_idx),
    .last_beat  (last_beat),
    .addr       (rom_addr)
  );

  assign penult = (beat_idx == IDX_W'(BEATS - 2));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_T1;
      ST_T1:   state_d = (first_q == '0) ? ST_TB2 : ST_TW;
      ST_TW:   if (tmr_expire) state_d = ST_TB2;
      ST_TB2: begin
        if (burst_q != '0)  state_d = ST_TWB;
        else if (penult)    state_d = ST_T2;
        else                state_d = ST_TB2;
      end
      ST_TWB:  if (tmr_expire) state_d = last_beat ? ST_T2 : ST_TB2;
      ST_T2:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy     = (state_q != ST_IDLE);
  assign rom_cs_n = !busy;
  assign rom_rd_n = !busy;
  assign rom_bs_n = (state_q != ST_T1);
  assign rom_rdwr = 1'b1;

  brom_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample      ((state_q == ST_TB2) || (state_q == ST_T2)),
    .sample_last (state_q == ST_T2),
    .bus_data    (rom_data),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_last    (rsp_last)
  );

  // R2
  bs_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_bs_n |-> $past(req_valid && req_ready));

  // R9
  bs_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_bs_n |-> $past(rom_cs_n));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_T1) |-> ($stable(first_q) && $stable(burst_q)));

  // R3
  select_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_cs_n) |-> !rom_bs_n);

endmodule

// File: tb/brom_burst_rd_bench.sv
module brom_burst_rd_bench;

  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;

  typedef struct {
    int          cyc;
    logic [31:0] data;
    logic        last;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0]        cfg_first_wait = '0;
  logic [2:0]        cfg_burst_wait = '0;
  logic              rsp_valid, rsp_last;
  logic [DATA_W-1:0] rsp_data;
  logic              rom_cs_n, rom_rd_n, rom_bs_n, rom_rdwr;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] romval(logic [ADDR_W-1:0] a);
    return ({6'h0, a} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  assign rom_data = romval(rom_addr);

  brom_burst_rd u_brom_burst_rd (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .cfg_first_wait(cfg_first_wait), .cfg_burst_wait(cfg_burst_wait),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .rom_cs_n(rom_cs_n), .rom_rd_n(rom_rd_n), .rom_bs_n(rom_bs_n),
    .rom_rdwr(rom_rdwr), .rom_addr(rom_addr), .rom_data(rom_data)
  );

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each response pulse (R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7", "unexpected rsp_valid", 64'(cyc), 64'(0));
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.cyc, "R7", "response cycle", 64'(cyc), 64'(e.cyc));
          chk(rsp_data == e.data, "R7", "response data", 64'(rsp_data), 64'(e.data));
          chk(rsp_last == e.last, "R7", "response last flag", 64'(rsp_last), 64'(e.last));
        end
      end else if (sb.size() != 0 && sb[0].cyc < cyc) begin
        exp_t e;
        e = sb.pop_front();
        chk(1'b0, "R7", "missing response", 64'(cyc), 64'(e.cyc));
      end
    end
  end

  // Driver: called just after a negedge; returns at the negedge of the first idle cycle.
  task automatic run_burst(logic [ADDR_W-1:0] a, int w1, int w2, bit hold, bit scramble);
    int a_cyc, s0, s3;
    logic [ADDR_W-1:0] base;
    req_valid      = 1'b1;
    req_addr       = a;
    cfg_first_wait = 3'(w1);
    cfg_burst_wait = 3'(w2);
    while (!req_ready) @(negedge clk);
    a_cyc = cyc + 1;
    base  = a & ~ADDR_W'(15);
    s0    = a_cyc + w1 + 1;              // R4: data cycle of the first beat
    s3    = s0 + 3 * (w2 + 1);           // R5: later beats
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.cyc  = s0 + k * (w2 + 1) + 1;
      e.data = romval(base + ADDR_W'(4 * k));
      e.last = (k == 3);
      sb.push_back(e);
    end
    @(negedge clk);
    for (int c = a_cyc; c <= s3; c++) begin
      if (c == a_cyc) begin
        if (!hold) req_valid = 1'b0;
        if (scramble) begin
          // R8: inputs disturbed after acceptance
          cfg_first_wait = ~3'(w1);
          cfg_burst_wait = ~3'(w2);
          req_addr       = ~a;
        end
      end
      chk(rom_cs_n == 1'b0, "R3", "cs_n inside burst", 64'(rom_cs_n), 64'(0));
      chk(rom_rd_n == 1'b0, "R3", "rd_n inside burst", 64'(rom_rd_n), 64'(0));
      chk(rom_rdwr == 1'b1, "R3", "rdwr inside burst", 64'(rom_rdwr), 64'(1));
      chk(rom_bs_n == (c != a_cyc), "R2", "bs_n timing", 64'(rom_bs_n), 64'(c != a_cyc));
      chk(req_ready == 1'b0, "R2", "ready low while busy", 64'(req_ready), 64'(0));
      if (c >= s0 && ((c - s0) % (w2 + 1)) == 0) begin
        int k;
        k = (c - s0) / (w2 + 1);
        chk(rom_addr == base + ADDR_W'(4 * k), "R6", "beat address",
            64'(rom_addr), 64'(base + ADDR_W'(4 * k)));
      end
      @(negedge clk);
    end
    // R9 / R4 / R5: strobes released right after the final data cycle
    chk(rom_cs_n == 1'b1, "R9", "cs_n after final beat", 64'(rom_cs_n), 64'(1));
    chk(rom_rd_n == 1'b1, "R9", "rd_n after final beat", 64'(rom_rd_n), 64'(1));
    chk(rom_bs_n == 1'b1, "R9", "bs_n after final beat", 64'(rom_bs_n), 64'(1));
    chk(req_ready == 1'b1, "R9", "ready after final beat", 64'(req_ready), 64'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rom_cs_n && rom_rd_n && rom_bs_n, "R1", "strobes in reset", 64'({rom_cs_n, rom_rd_n, rom_bs_n}), 64'(7));
    chk(rom_rdwr == 1'b1, "R1", "rdwr in reset", 64'(rom_rdwr), 64'(1));
    chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'(1));
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rom_cs_n == 1'b1, "R1", "cs_n after reset", 64'(rom_cs_n), 64'(1));
    chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'(1));

    run_burst(26'h0001230, 2, 1, 1'b0, 1'b0);   // R4 R5 example timing
    @(negedge clk);
    run_burst(26'h00ABCDE, 0, 0, 1'b0, 1'b0);   // R10 zero waits, R6 low bits ignored
    @(negedge clk);
    run_burst(26'h0100004, 7, 7, 1'b0, 1'b0);   // R4 R5 longest waits
    @(negedge clk);
    run_burst(26'h0222229, 3, 2, 1'b0, 1'b1);   // R8 inputs disturbed
    @(negedge clk);
    run_burst(26'h0004440, 1, 0, 1'b1, 1'b1);   // R9 held request, back to back
    run_burst(26'h0008888, 0, 3, 1'b1, 1'b0);   // R9 second back-to-back line
    run_burst(26'h3FFFFF7, 5, 1, 1'b0, 1'b0);   // R6 top of address space
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R7", "all responses seen", 64'(sb.size()), 64'(0));
    chk(rsp_valid == 1'b0, "R7", "no stray response", 64'(rsp_valid), 64'(0));
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule